// File: doc/BRIEF.md
# Discrete Sense SPI Register Target

This block is the register front end of a 32-channel discrete-input sensor. A host reaches it over a four-wire serial link in SPI mode 0 with an active-low chip select. The block samples the serial pins with its own system clock. It then decodes a leading command byte whose top bit chooses read or write and whose low seven bits name a register. After that it either streams register data back or takes in one or two data bytes.

The registers are:
- a control byte, with a test-mode bit and a self-clearing soft reset;
- a sensing-mode byte, with one bit per bank of eight channels;
- two 16-bit threshold words, one for ground-open sensing and one for supply-open sensing. Each word holds the hysteresis in its high byte and the sum of the two thresholds in its low byte;
- read-only views of the 32 sense inputs, either one bank at a time or all at once.

The configuration registers are also driven out as plain outputs, so the comparator logic outside can use them.

An odd hysteresis value is illegal. Writing one stores the word and puts the block into a lock state. In that state every read returns zeros and every write is dropped. Only a hardware reset or a soft reset brings the block back.

Top module: `discrete_sense_spi`

## Requirements
- R1: After hardware reset, testMode, bankMode, gndThresh and supThresh are all zero, locked is 0 and miso is 0.
- R2: The first byte of each transaction is a command: bit 7 = 1 means read and bit 7 = 0 means write, and bits 6..0 are the register address. A read of control address 0x02 returns {7'b0, testMode} as its first byte.
- R3: Read data leaves most significant bit first, starting with the first clock after the command. Address 0x78 returns all 32 sense bits as four bytes, channel 31 first. Addresses 0x3A and 0x3C return the hysteresis byte and then the sum byte. Bytes clocked beyond a register's width read as zero.
- R4: A one-byte write to 0x02 sets testMode from data bit 0. A one-byte write to 0x04 sets bankMode from data bits 3..0, where bit k selects supply-open (1) or ground-open (0) sensing for channels 8k..8k+7.
- R5: A write to 0x3A (ground-open) or 0x3C (supply-open) takes the high byte and then the low byte. The word changes only when the second data byte completes.
- R6: The bytes at 0x10, 0x12, 0x14 and 0x16 return channels 7..0, 15..8, 23..16 and 31..24, with the highest channel of each bank as the MSB.
- R7: All sense data returned by a read is captured when the command byte completes. Later changes on senseIn within the same transaction do not alter it.
- R8: A write to 0x02 with data bit 1 set returns every register to its reset value and clears the lock. Bit 1 always reads back as 0.
- R9: A completed threshold-word write whose hysteresis is odd (word bit 8 = 1) stores the word and raises locked.
- R10: While locked, every read returns zero and every write has no effect, except a control write with bit 1 set.
- R11: Raising chip select before a byte completes discards that byte. A word write cut off after its first data byte leaves the word unchanged.
- R12: Unmapped addresses read as 0x00. Writes to read-only or unmapped addresses change nothing.
- R13: miso is 0 while chip select is high and while the command byte is being shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| sclk | input | 1 | Serial clock, idle low |
| csN | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| senseIn | input | NUM_CH | Parallel sense state, bit n = channel n |
| testMode | output | 1 | Test-mode enable from the control register |
| bankMode | output | NUM_CH/8 | Sensing mode per bank of eight channels |
| gndThresh | output | 16 | Ground-open threshold word (hysteresis, sum) |
| supThresh | output | 16 | Supply-open threshold word (hysteresis, sum) |
| locked | output | 1 | High while in the lock state |

## Verification
If the bit counter or the command latch slips, the error shows on miso within the very next data bit: a read returns a neighbouring register or shifted data. If a write strobe is wrong, the configuration outputs differ from the model on the clock after the byte completes. A lock flag that sets or clears wrongly shows at once on locked, and from then on as frozen or unfrozen outputs and as zero read data. A stale or late sense snapshot only shows if senseIn changes during a read, so the bench changes it on purpose in the middle of a four-byte read.

// File: rtl/dsense_pkg.sv
package dsense_pkg;

  // Register addresses (seven bits, carried in the low bits of the command)
  localparam logic [6:0] ADDR_CTRL        = 7'h02;
  localparam logic [6:0] ADDR_MODE        = 7'h04;
  localparam logic [6:0] ADDR_SENSE_BYTE0 = 7'h10;
  localparam logic [6:0] ADDR_GND_TH      = 7'h3A;
  localparam logic [6:0] ADDR_SUP_TH      = 7'h3C;
  localparam logic [6:0] ADDR_SENSE_ALL   = 7'h78;

  // Control byte fields
  localparam int CTRL_TEST_BIT = 0;
  localparam int CTRL_SRST_BIT = 1;

  // Hysteresis parity bit inside a threshold word
  localparam int HYST_LSB = 8;

  // Strobes from the serial control to the register datapath
  typedef struct packed {
    logic       capture;    // read command byte complete: snapshot and load
    logic       shiftOut;   // advance the read shifter by one bit
    logic       dataByte0;  // first data byte of a write complete
    logic       dataByte1;  // second data byte of a write complete
    logic [6:0] addr;       // register address of this transaction
    logic [7:0] rxByte;     // byte that just completed
  } dsStrobe_t;

endpackage

// File: rtl/dsense_spi_ctrl.sv
module dsense_spi_ctrl
  import dsense_pkg::*;
#(
  parameter int SYNC_STAGES = 2   // at least 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclkIn,
  input  logic      csNIn,
  input  logic      mosiIn,
  output dsStrobe_t stb,
  output logic      readPhase
);

  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

  // Pin synchronisers
  logic [SYNC_STAGES-1:0] sclkPipe, csPipe, mosiPipe;
  logic sclkS, csActive, mosiS, sclkLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      mosiPipe <= '0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclkIn};
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csNIn};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosiIn};
    end
  end

  assign sclkS    = sclkPipe[SYNC_STAGES-1];
  assign csActive = !csPipe[SYNC_STAGES-1];
  assign mosiS    = mosiPipe[SYNC_STAGES-1];

  // Framing state
  logic [CNT_W-1:0] bitCnt;
  logic [6:0]       rxShift;
  logic             cmdSeen, isRead;
  logic [6:0]       addrQ;
  logic [1:0]       dataCnt;
  logic             sclkRise, byteEnd;
  logic [7:0]       rxNext;

  assign sclkRise = csActive && sclkS && !sclkLast;
  assign byteEnd  = sclkRise && (bitCnt == LAST_BIT);
  assign rxNext   = {rxShift, mosiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkLast <= 1'b0;
      bitCnt   <= '0;
      rxShift  <= '0;
      cmdSeen  <= 1'b0;
      isRead   <= 1'b0;
      addrQ    <= '0;
      dataCnt  <= '0;
    end else begin
      sclkLast <= sclkS;
      if (!csActive) begin
        bitCnt  <= '0;
        cmdSeen <= 1'b0;
        isRead  <= 1'b0;
        dataCnt <= '0;
      end else if (sclkRise) begin
        bitCnt  <= bitCnt + 1'b1;
        rxShift <= rxNext[6:0];
        if (byteEnd) begin
          if (!cmdSeen) begin
            cmdSeen <= 1'b1;
            isRead  <= rxNext[7];
            addrQ   <= rxNext[6:0];
          end else if (dataCnt != 2'd3) begin
            dataCnt <= dataCnt + 2'd1;
          end
        end
      end
    end
  end

  always_comb begin
    stb.capture   = byteEnd && !cmdSeen && rxNext[7];
    stb.shiftOut  = sclkRise && cmdSeen && isRead;
    stb.dataByte0 = byteEnd && cmdSeen && !isRead && (dataCnt == 2'd0);
    stb.dataByte1 = byteEnd && cmdSeen && !isRead && (dataCnt == 2'd1);
    stb.addr      = cmdSeen ? addrQ : rxNext[6:0];
    stb.rxByte    = rxNext;
  end

  assign readPhase = csActive && cmdSeen && isRead;

endmodule

// File: rtl/dsense_regfile.sv
module dsense_regfile
  import dsense_pkg::*;
#(
  parameter int NUM_CH = 32   // multiple of 8, at least 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dsStrobe_t              stb,
  input  logic                   readPhase,
  input  logic [NUM_CH-1:0]      senseIn,
  output logic                   miso,
  output logic                   testMode,
  output logic [NUM_CH/8-1:0]    bankMode,
  output logic [15:0]            gndThresh,
  output logic [15:0]            supThresh,
  output logic                   locked
);

  localparam int BANKS = NUM_CH / 8;
  localparam int TX_W  = NUM_CH;

  logic [TX_W-1:0] txReg;
  logic [TX_W-1:0] readVal;
  logic [7:0]      highHold;
  logic [BANKS-1:0] byteHit;
  logic            softRst;

  // One decode per sense bank
  genvar k;
  generate
    for (k = 0; k < BANKS; k++) begin : g_bank_hit
      assign byteHit[k] = (stb.addr == ADDR_SENSE_BYTE0 + 7'(2 * k));
    end
  endgenerate

  // Read value, left-justified so the first byte sits at the MSB end
  always_comb begin
    readVal = '0;
    if (stb.addr == ADDR_CTRL)
      readVal[TX_W-1 -: 8] = {7'b0, testMode};
    else if (stb.addr == ADDR_MODE)
      readVal[TX_W-1 -: 8] = 8'(bankMode);
    else if (stb.addr == ADDR_GND_TH)
      readVal[TX_W-1 -: 16] = gndThresh;
    else if (stb.addr == ADDR_SUP_TH)
      readVal[TX_W-1 -: 16] = supThresh;
    else if (stb.addr == ADDR_SENSE_ALL)
      readVal = senseIn;
    for (int b = 0; b < BANKS; b++)
      if (byteHit[b]) readVal[TX_W-1 -: 8] = senseIn[8*b +: 8];
  end

  assign softRst = stb.dataByte0 && (stb.addr == ADDR_CTRL) && stb.rxByte[CTRL_SRST_BIT];

  // Read shifter: loaded at the end of the command byte, which is the snapshot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '0;
    end else if (stb.capture) begin
      txReg <= locked ? '0 : readVal;
    end else if (stb.shiftOut) begin
      txReg <= {txReg[TX_W-2:0], 1'b0};
    end
  end

  // Configuration registers and lock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      testMode  <= 1'b0;
      bankMode  <= '0;
      gndThresh <= '0;
      supThresh <= '0;
      highHold  <= '0;
      locked    <= 1'b0;
    end else if (softRst) begin
      testMode  <= 1'b0;
      bankMode  <= '0;
      gndThresh <= '0;
      supThresh <= '0;
      highHold  <= '0;
      locked    <= 1'b0;
    end else if (!locked) begin
      if (stb.dataByte0) begin
        if (stb.addr == ADDR_CTRL)
          testMode <= stb.rxByte[CTRL_TEST_BIT];
        else if (stb.addr == ADDR_MODE)
          bankMode <= stb.rxByte[BANKS-1:0];
        else if (stb.addr == ADDR_GND_TH || stb.addr == ADDR_SUP_TH)
          highHold <= stb.rxByte;
      end
      if (stb.dataByte1) begin
        if (stb.addr == ADDR_GND_TH) begin
          gndThresh <= {highHold, stb.rxByte};
          locked    <= highHold[HYST_LSB-8];
        end else if (stb.addr == ADDR_SUP_TH) begin
          supThresh <= {highHold, stb.rxByte};
          locked    <= highHold[HYST_LSB-8];
        end
      end
    end
  end

  assign miso = readPhase && !locked && txReg[TX_W-1];

endmodule

// File: rtl/discrete_sense_spi.sv
module discrete_sense_spi
  import dsense_pkg::*;
#(
  parameter int NUM_CH      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclk,
  input  logic                csN,
  input  logic                mosi,
  output logic                miso,
  input  logic [NUM_CH-1:0]   senseIn,
  output logic                testMode,
  output logic [NUM_CH/8-1:0] bankMode,
  output logic [15:0]         gndThresh,
  output logic [15:0]         supThresh,
  output logic                locked
);

  dsStrobe_t stb;
  logic      readPhase;

  dsense_spi_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclkIn    (sclk),
    .csNIn     (csN),
    .mosiIn    (mosi),
    .stb       (stb),
    .readPhase (readPhase)
  );

  dsense_regfile #(.NUM_CH(NUM_CH)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .readPhase (readPhase),
    .senseIn   (senseIn),
    .miso      (miso),
    .testMode  (testMode),
    .bankMode  (bankMode),
    .gndThresh (gndThresh),
    .supThresh (supThresh),
    .locked    (locked)
  );

endmodule

// File: rtl/discrete_sense_spi_chk.sv
module discrete_sense_spi_chk
  import dsense_pkg::*;
#(
  parameter int BANKS = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             miso,
  input logic             testMode,
  input logic [BANKS-1:0] bankMode,
  input logic [15:0]      gndThresh,
  input logic [15:0]      supThresh,
  input logic             locked,
  input logic             readPhase,
  input dsStrobe_t        stb
);

  logic srstSeen;
  assign srstSeen = stb.dataByte0 && (stb.addr == ADDR_CTRL) && stb.rxByte[CTRL_SRST_BIT];

  // R13: no data on miso outside the read data phase
  p_idle_miso_r13: assert property (@(posedge clk) disable iff (!rstN)
    !readPhase |-> !miso);

  // R10: lock silences read data
  p_lock_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> !miso);

  // R10: lock freezes configuration unless soft reset
  p_lock_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    locked && !srstSeen |=> $stable(testMode) && $stable(bankMode) &&
                            $stable(gndThresh) && $stable(supThresh) && locked);

  // R8: soft reset restores reset values and releases lock
  p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rstN)
    srstSeen |=> !locked && !testMode && (bankMode == '0) &&
                 (gndThresh == 16'h0) && (supThresh == 16'h0));

  // R9: an odd hysteresis can only be present while locked
  p_even_hyst_r9: assert property (@(posedge clk) disable iff (!rstN)
    !locked |-> !gndThresh[HYST_LSB] && !supThresh[HYST_LSB]);

  // R2: at most one framing strobe per cycle
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.capture, stb.shiftOut, stb.dataByte0, stb.dataByte1}));

endmodule

bind discrete_sense_spi discrete_sense_spi_chk #(.BANKS(NUM_CH/8)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .miso      (miso),
  .testMode  (testMode),
  .bankMode  (bankMode),
  .gndThresh (gndThresh),
  .supThresh (supThresh),
  .locked    (locked),
  .readPhase (readPhase),
  .stb       (stb)
);

// File: tb/test_discrete_sense_spi.sv
module test_discrete_sense_spi;

  localparam int H = 6;  // system clocks per serial half period

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, sclk, csN, mosi;
  logic [31:0] senseIn;
  logic        miso, testMode, locked;
  logic [3:0]  bankMode;
  logic [15:0] gndThresh, supThresh;

  discrete_sense_spi i_discrete_sense_spi (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .senseIn(senseIn), .testMode(testMode), .bankMode(bankMode),
    .gndThresh(gndThresh), .supThresh(supThresh), .locked(locked)
  );

  int compared = 0;
  int mismatched = 0;
  bit monEn = 1'b0;
  bit done = 1'b0;

  // Behavioural model state
  logic        mTest, mLock;
  logic [3:0]  mBank;
  logic [15:0] mGnd, mSup;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string req, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mTest = 1'b0; mLock = 1'b0; mBank = '0; mGnd = '0; mSup = '0;
  endtask

  function automatic logic [31:0] expRead(input logic [6:0] a);
    logic [31:0] r;
    r = '0;
    if (!mLock) begin
      case (a)
        7'h02: r = {7'b0, mTest, 24'h0};
        7'h04: r = {4'b0, mBank, 24'h0};
        7'h3A: r = {mGnd, 16'h0};
        7'h3C: r = {mSup, 16'h0};
        7'h10: r = {senseIn[7:0], 24'h0};
        7'h12: r = {senseIn[15:8], 24'h0};
        7'h14: r = {senseIn[23:16], 24'h0};
        7'h16: r = {senseIn[31:24], 24'h0};
        7'h78: r = senseIn;
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  task automatic applyWrite(input logic [7:0] cmd, input int nData, input logic [31:0] w);
    logic [6:0] a;
    logic [7:0] b0, b1;
    a  = cmd[6:0];
    b0 = w[8*(nData-1) +: 8];
    b1 = w[7:0];
    if (a == 7'h02 && b0[1]) modelReset();
    else if (!mLock) begin
      if (a == 7'h02) mTest = b0[0];
      else if (a == 7'h04) mBank = b0[3:0];
      else if ((a == 7'h3A || a == 7'h3C) && nData >= 2) begin
        if (a == 7'h3A) mGnd = {b0, b1}; else mSup = {b0, b1};
        mLock = b0[0];
      end
    end
  endtask

  // Per-clock comparison of the configuration outputs while the bus is idle
  always @(negedge clk) begin
    if (monEn) begin
      chk({31'b0, testMode}, {31'b0, mTest}, "R4", "testMode");
      chk({28'b0, bankMode}, {28'b0, mBank}, "R4", "bankMode");
      chk({16'b0, gndThresh}, {16'b0, mGnd}, "R5", "gndThresh");
      chk({16'b0, supThresh}, {16'b0, mSup}, "R5", "supThresh");
      chk({31'b0, locked}, {31'b0, mLock}, "R9", "locked");
      chk({31'b0, miso}, 32'd0, "R13", "miso idle");
    end
  end

  task automatic xfer(input logic [7:0] cmd, input int nData, input logic [31:0] wdata,
                      input logic [31:0] expRd, input string req, input int stopAt,
                      input bit lateEn, input logic [31:0] lateVal);
    int total;
    monEn = 1'b0;
    @(negedge clk);
    csN = 1'b0;
    repeat (H) @(negedge clk);
    total = (stopAt > 0) ? stopAt : 8 * (1 + nData);
    for (int b = 0; b < total; b++) begin
      int byteI;
      int bitI;
      byteI = b / 8;
      bitI  = 7 - (b % 8);
      if (b == 8 && lateEn) senseIn = lateVal;
      if (byteI == 0) mosi = cmd[bitI];
      else if (cmd[7]) mosi = 1'b0;
      else mosi = wdata[8*(nData-byteI) + bitI];
      repeat (H) @(negedge clk);
      if (cmd[7] && byteI > 0)
        chk({31'b0, miso}, {31'b0, expRd[31-(b-8)]}, req, "miso read bit");
      else
        chk({31'b0, miso}, 32'd0, "R13", "miso before read data");
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    csN  = 1'b1;
    mosi = 1'b0;
    repeat (8) @(negedge clk);
    if (!cmd[7] && stopAt <= 0) applyWrite(cmd, nData, wdata);
    monEn = 1'b1;
  endtask

  task automatic wr8(input logic [6:0] a, input logic [7:0] v, input string req);
    xfer({1'b0, a}, 1, {24'h0, v}, 32'h0, req, 0, 1'b0, 32'h0);
  endtask

  task automatic wr16(input logic [6:0] a, input logic [15:0] v, input string req);
    xfer({1'b0, a}, 2, {16'h0, v}, 32'h0, req, 0, 1'b0, 32'h0);
  endtask

  task automatic rd(input logic [6:0] a, input int n, input string req);
    xfer({1'b1, a}, n, 32'h0, expRead(a), req, 0, 1'b0, 32'h0);
  endtask

  task automatic hwReset();
    monEn = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    modelReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic checkResetState();
    chk({31'b0, testMode}, 32'd0, "R1", "testMode after reset");
    chk({28'b0, bankMode}, 32'd0, "R1", "bankMode after reset");
    chk({16'b0, gndThresh}, 32'd0, "R1", "gndThresh after reset");
    chk({16'b0, supThresh}, 32'd0, "R1", "supThresh after reset");
    chk({31'b0, locked}, 32'd0, "R1", "locked after reset");
    chk({31'b0, miso}, 32'd0, "R1", "miso after reset");
  endtask

  initial begin
    rstN = 1'b0; sclk = 1'b0; csN = 1'b1; mosi = 1'b0; senseIn = '0;
    modelReset();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkResetState();
    monEn = 1'b1;

    // R4 / R2: control byte write and readback
    wr8(7'h02, 8'h01, "R4");
    rd(7'h02, 1, "R2");
    rd(7'h02, 2, "R3");   // second byte reads zero

    // R4: sensing mode
    wr8(7'h04, 8'h05, "R4");
    rd(7'h04, 1, "R4");
    wr8(7'h04, 8'hFA, "R4"); // upper bits dropped
    rd(7'h04, 1, "R4");

    // R5 / R3: threshold words
    wr16(7'h3A, 16'h0A14, "R5");
    wr16(7'h3C, 16'h0420, "R5");
    rd(7'h3A, 2, "R3");
    rd(7'h3C, 2, "R3");

    // R6 / R3: sense views under two patterns
    senseIn = 32'hA1B2C3D4;
    rd(7'h10, 1, "R6");
    rd(7'h12, 1, "R6");
    rd(7'h14, 1, "R6");
    rd(7'h16, 1, "R6");
    rd(7'h78, 4, "R3");
    rd(7'h78, 1, "R3");
    senseIn = 32'h0F1E2D3C;
    rd(7'h78, 4, "R3");
    rd(7'h14, 2, "R6");

    // R7: sense changes after the command byte do not reach the read
    senseIn = 32'h11223344;
    xfer(8'hF8, 4, 32'h0, expRead(7'h78), "R7", 0, 1'b1, 32'hFFFF0000);
    rd(7'h10, 1, "R7");   // new value visible on the next transaction

    // R12: unmapped and read-only addresses
    rd(7'h20, 1, "R12");
    rd(7'h11, 2, "R12");
    wr8(7'h10, 8'hFF, "R12");
    wr16(7'h30, 16'h1234, "R12");
    rd(7'h10, 1, "R12");

    // R11: aborted transfers
    xfer(8'h04, 1, 32'h0000000F, 32'h0, "R11", 12, 1'b0, 32'h0);
    chk({28'b0, bankMode}, {28'b0, mBank}, "R11", "bankMode after abort");
    xfer(8'h3A, 2, 32'h00000606, 32'h0, "R11", 16, 1'b0, 32'h0);
    chk({16'b0, gndThresh}, {16'b0, mGnd}, "R11", "gndThresh after partial word");
    xfer(8'h3C, 2, 32'h00000808, 32'h0, "R11", 20, 1'b0, 32'h0);
    chk({16'b0, supThresh}, {16'b0, mSup}, "R11", "supThresh after cut second byte");

    // R9: odd hysteresis locks
    wr16(7'h3C, 16'h0320, "R9");
    chk({31'b0, locked}, 32'd1, "R9", "locked after odd hysteresis");
    chk({16'b0, supThresh}, 32'h0320, "R9", "supThresh stored with odd hysteresis");

    // R10: locked behaviour
    rd(7'h02, 1, "R10");
    rd(7'h78, 4, "R10");
    wr8(7'h04, 8'h0F, "R10");
    chk({28'b0, bankMode}, {28'b0, mBank}, "R10", "bankMode frozen while locked");
    wr16(7'h3A, 16'h0202, "R10");
    wr8(7'h02, 8'h00, "R10");
    chk({31'b0, testMode}, 32'd1, "R10", "testMode frozen while locked");

    // R8: soft reset clears everything and self-clears
    wr8(7'h02, 8'h03, "R8");
    chk({31'b0, locked}, 32'd0, "R8", "locked after soft reset");
    chk({16'b0, gndThresh}, 32'd0, "R8", "gndThresh after soft reset");
    rd(7'h02, 1, "R8");

    // R1 / R9: hardware reset also clears lock
    wr8(7'h04, 8'h09, "R4");
    wr16(7'h3A, 16'h0102, "R9");
    chk({31'b0, locked}, 32'd1, "R9", "locked on ground word");
    hwReset();
    checkResetState();
    monEn = 1'b1;
    rd(7'h3A, 2, "R1");

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL R13 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule